// File: doc/BRIEF.md
# Branch Prediction Recovery Unit

This block sits in the front end of a four-stage execution pipeline and handles control transfers that are resolved statically at decode. A conditional jump carries its own prediction (taken or not taken). At decode the block works out the predicted next PC and the alternate PC in the same cycle, asks fetch to jump when the predicted path leaves the sequential stream, and sends the alternate PC down a short PC pipeline next to the instruction. Three cycles after decode the execute stage returns a condition flag for the branch, which is now in stage 3. A high flag means the prediction was wrong. The block then raises an abort, throws away the younger work in stages 1 and 2, and redirects fetch to the alternate PC carried by the branch.

Calls and returns use a small return-address stack. The stack is updated only when the instruction leaves stage 4, so a call or return that is squashed on the way never changes it. A return reads the top of the stack at decode. For that read to be correct, no call or return may still be in flight, so the block refuses a return until the pipeline holds none. Every redirect of fetch is followed by one dead decode cycle while the instruction buffer refills. A cache reject freezes the pipeline. A reject that comes with a fault aborts and flushes it.

Top module: `brp_unit`

## Requirements
- R1: Reset clears the stages, puts the front end in the running state and sets every return-stack entry to zero, so a return decoded first after reset is accepted and redirects fetch to 0.
- R2: A conditional jump predicted not taken (`dec_kind` = 1) gives `dec_next_pc` = PC+3 and does not redirect fetch. It carries PC+literal as its alternate address.
- R3: An accepted conditional jump predicted taken (`dec_kind` = 2) or an accepted unconditional jump (`dec_kind` = 3) raises `fetch_jump` in its decode cycle with `fetch_pc` = PC+literal. A taken conditional jump carries PC+3 as its alternate address.
- R4: When a conditional jump is in stage 3 (the third cycle after its decode) and `ex_cond` is high with no cache reject, `abort` rises and fetch is redirected to that branch's alternate address in the same cycle. With `ex_cond` low nothing happens.
- R5: While `cache_reject` is high, `abort` equals `cache_fault`. A reject without a fault freezes all stages and the return stack and refuses decode, and the pipeline resumes afterwards. A reject with a fault empties every stage.
- R6: In an abort cycle decode is refused and stages 1 and 2 are squashed. A squashed branch never raises abort, never redirects fetch and never touches the return stack.
- R7: In the cycle after any `fetch_jump`, decode is refused (a refill cycle).
- R8: A call (`dec_kind` = 4) redirects fetch to PC+literal. It pushes PC+`dec_len` onto the return stack only as it leaves stage 4.
- R9: A return (`dec_kind` = 5) is refused while any call or return sits in stages 1 to 4. An accepted return redirects fetch to the top stack entry and pops the stack when it leaves stage 4.
- R10: The return stack has 8 entries and its pointer wraps: a ninth push overwrites the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | An instruction is offered at decode |
| dec_kind | input | 3 | Control kind: 0 plain, 1 cond not taken, 2 cond taken, 3 jump, 4 call, 5 return |
| dec_pc | input | 32 | PC of the decoded instruction |
| dec_lit | input | 32 | Jump displacement |
| dec_len | input | 3 | Instruction length (return offset of a call) |
| ex_cond | input | 1 | Condition flag returned for the branch in stage 3 |
| cache_reject | input | 1 | Data cache reject |
| cache_fault | input | 1 | Data cache fault, valid with reject |
| dec_accept | output | 1 | The offered instruction is taken this cycle |
| dec_next_pc | output | 32 | Predicted next PC of the decoded instruction |
| fetch_jump | output | 1 | Fetch must restart at `fetch_pc` |
| fetch_pc | output | 32 | Redirect address |
| abort | output | 1 | Pipeline abort |

## Verification
Decode-side results (`dec_accept`, `dec_next_pc`, and the redirect of a taken jump, call or return) depend only on the inputs and state, so they are due in the cycle the instruction is presented. A misprediction redirect and abort are due three cycles after decode, when the branch reaches stage 3. Stack effects show up at the earliest five cycles after the call, through the redirect of a later return. The driver sets the inputs at the falling edge and queues every redirect it expects for that cycle. A monitor samples a little later in the same low phase, before the next rising edge, and matches each `fetch_jump` against the queue in order. Any extra or missing redirect counts as a failure.

// File: rtl/brp_pkg.sv
package brp_pkg;

    typedef enum logic [2:0] {
        BK_PLAIN = 3'd0,
        BK_CJ_NT = 3'd1,
        BK_CJ_T  = 3'd2,
        BK_JUMP  = 3'd3,
        BK_CALL  = 3'd4,
        BK_RET   = 3'd5
    } br_kind_e;

    typedef enum logic {
        FE_RUN    = 1'b0,
        FE_REFILL = 1'b1
    } fe_state_e;

endpackage

// File: rtl/brp_decode.sv
module brp_decode
    import brp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int LEN_W = 3,
    parameter int JLEN  = 3
) (
    input  br_kind_e           kind,
    input  logic [PC_W-1:0]    pc,
    input  logic [PC_W-1:0]    lit,
    input  logic [LEN_W-1:0]   len,
    input  logic [PC_W-1:0]    ras_top,
    output logic [PC_W-1:0]    next_pc,
    output logic [PC_W-1:0]    alt_pc,
    output logic               redir
);
    logic [PC_W-1:0] seq_jmp, seq_len, tgt;

    assign seq_jmp = pc + PC_W'(JLEN);
    assign seq_len = pc + PC_W'(len);
    assign tgt     = pc + lit;

    always_comb begin
        next_pc = seq_len;
        alt_pc  = '0;
        redir   = 1'b0;
        unique case (kind)
            BK_CJ_NT: begin next_pc = seq_jmp; alt_pc = tgt;     end
            BK_CJ_T:  begin next_pc = tgt;     alt_pc = seq_jmp; redir = 1'b1; end
            BK_JUMP:  begin next_pc = tgt;     alt_pc = seq_jmp; redir = 1'b1; end
            BK_CALL:  begin next_pc = tgt;     alt_pc = seq_len; redir = 1'b1; end
            BK_RET:   begin next_pc = ras_top; alt_pc = seq_len; redir = 1'b1; end
            default:  begin next_pc = seq_len; end
        endcase
    end
endmodule

// File: rtl/brp_pipe.sv
module brp_pipe
    import brp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int NSTAGE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             flush_all,
    input  logic             flush_young,
    input  logic             in_valid,
    input  br_kind_e         in_kind,
    input  logic [PC_W-1:0]  in_alt,
    output logic             chk_valid,
    output br_kind_e         chk_kind,
    output logic [PC_W-1:0]  chk_alt,
    output logic             tail_valid,
    output br_kind_e         tail_kind,
    output logic [PC_W-1:0]  tail_alt,
    output logic             ctl_busy
);
    localparam int CHK = NSTAGE - 1;

    logic [NSTAGE:1]  v_q;
    br_kind_e         k_q [1:NSTAGE];
    logic [PC_W-1:0]  a_q [1:NSTAGE];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            for (int s = 1; s <= NSTAGE; s++) begin
                k_q[s] <= BK_PLAIN;
                a_q[s] <= '0;
            end
        end else if (flush_all) begin
            v_q <= '0;
        end else if (!hold) begin
            if (flush_young)
                v_q <= {v_q[CHK], {CHK{1'b0}}};
            else
                v_q <= {v_q[NSTAGE-1:1], in_valid};
            k_q[1] <= in_kind;
            a_q[1] <= in_alt;
            for (int s = 2; s <= NSTAGE; s++) begin
                k_q[s] <= k_q[s-1];
                a_q[s] <= a_q[s-1];
            end
        end
    end

    always_comb begin
        ctl_busy = 1'b0;
        for (int s = 1; s <= NSTAGE; s++)
            if (v_q[s] && (k_q[s] == BK_CALL || k_q[s] == BK_RET))
                ctl_busy = 1'b1;
    end

    assign chk_valid  = v_q[CHK];
    assign chk_kind   = k_q[CHK];
    assign chk_alt    = a_q[CHK];
    assign tail_valid = v_q[NSTAGE];
    assign tail_kind  = k_q[NSTAGE];
    assign tail_alt   = a_q[NSTAGE];
endmodule

// File: rtl/brp_ras.sv
module brp_ras #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 8,
    localparam int SP_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [PC_W-1:0]  wdata,
    output logic [PC_W-1:0]  top,
    output logic [SP_W-1:0]  level
);
    logic [PC_W-1:0] mem [DEPTH];
    logic [SP_W-1:0] sp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            mem[sp] <= wdata;
            sp      <= sp + SP_W'(1);
        end else if (pop) begin
            sp      <= sp - SP_W'(1);
        end
    end

    assign top   = mem[sp - SP_W'(1)];
    assign level = sp;
endmodule

// File: rtl/brp_unit.sv
module brp_unit
    import brp_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int LEN_W     = 3,
    parameter int NSTAGE    = 4,
    parameter int RAS_DEPTH = 8,
    parameter int JLEN      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [2:0]       dec_kind,
    input  logic [PC_W-1:0]  dec_pc,
    input  logic [PC_W-1:0]  dec_lit,
    input  logic [LEN_W-1:0] dec_len,
    input  logic             ex_cond,
    input  logic             cache_reject,
    input  logic             cache_fault,
    output logic             dec_accept,
    output logic [PC_W-1:0]  dec_next_pc,
    output logic             fetch_jump,
    output logic [PC_W-1:0]  fetch_pc,
    output logic             abort
);
    localparam int SP_W = $clog2(RAS_DEPTH);

    br_kind_e        kind;
    fe_state_e       state_q, state_d;
    logic [PC_W-1:0] alt_pc, ras_top;
    logic            dec_redir;
    logic            chk_valid, tail_valid, ctl_busy;
    br_kind_e        chk_kind, tail_kind;
    logic [PC_W-1:0] chk_alt, tail_alt;
    logic            hold, flush_all, chk_cond, mispredict, ret_block;
    logic [SP_W-1:0] ras_sp;

    assign kind = br_kind_e'(dec_kind);

    brp_decode #(.PC_W(PC_W), .LEN_W(LEN_W), .JLEN(JLEN)) u_dec (
        .kind(kind), .pc(dec_pc), .lit(dec_lit), .len(dec_len),
        .ras_top(ras_top), .next_pc(dec_next_pc), .alt_pc(alt_pc),
        .redir(dec_redir)
    );

    brp_pipe #(.PC_W(PC_W), .NSTAGE(NSTAGE)) u_pipe (
        .clk(clk), .rst_n(rst_n), .hold(hold), .flush_all(flush_all),
        .flush_young(mispredict), .in_valid(dec_accept), .in_kind(kind),
        .in_alt(alt_pc), .chk_valid(chk_valid), .chk_kind(chk_kind),
        .chk_alt(chk_alt), .tail_valid(tail_valid), .tail_kind(tail_kind),
        .tail_alt(tail_alt), .ctl_busy(ctl_busy)
    );

    brp_ras #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
        .clk(clk), .rst_n(rst_n),
        .push(tail_valid && tail_kind == BK_CALL && !hold),
        .pop(tail_valid && tail_kind == BK_RET && !hold),
        .wdata(tail_alt), .top(ras_top), .level(ras_sp)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FE_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        hold       = cache_reject && !cache_fault;
        flush_all  = cache_reject && cache_fault;
        chk_cond   = chk_valid && (chk_kind == BK_CJ_NT || chk_kind == BK_CJ_T);
        mispredict = chk_cond && ex_cond && !cache_reject;
        abort      = cache_reject ? cache_fault : (chk_cond && ex_cond);
        ret_block  = (kind == BK_RET) && ctl_busy;
        dec_accept = dec_valid && (state_q == FE_RUN) && !cache_reject
                     && !abort && !ret_block;
        fetch_jump = mispredict || (dec_accept && dec_redir);
        fetch_pc   = mispredict ? chk_alt : dec_next_pc;
        state_d    = state_q;
        unique case (state_q)
            FE_RUN:    if (fetch_jump) state_d = FE_REFILL;
            FE_REFILL: if (!hold && !fetch_jump) state_d = FE_RUN;
            default:   state_d = FE_RUN;
        endcase
    end
endmodule

// File: rtl/brp_unit_chk.sv
module brp_unit_chk #(
    parameter int SP_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dec_accept,
    input logic [2:0]      dec_kind,
    input logic            fetch_jump,
    input logic            abort,
    input logic            cache_reject,
    input logic            cache_fault,
    input logic            ctl_busy,
    input logic [SP_W-1:0] ras_sp
);
    assert_dead_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_jump |=> !dec_accept);

    assert_abort_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> !dec_accept);

    assert_ret_interlock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_accept && dec_kind == 3'd5) |-> !ctl_busy);

    assert_mispredict_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !cache_reject) |-> fetch_jump);

    assert_fault_no_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_reject && cache_fault) |-> !fetch_jump);

    assert_hold_stack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_reject && !cache_fault) |=> $stable(ras_sp));

    assert_ras_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ras_sp == $past(ras_sp)) || (ras_sp == SP_W'($past(ras_sp) + 1'b1))
                 || (ras_sp == SP_W'($past(ras_sp) - 1'b1)));
endmodule

bind brp_unit brp_unit_chk #(.SP_W($clog2(RAS_DEPTH))) u_chk (
    .clk(clk), .rst_n(rst_n), .dec_accept(dec_accept), .dec_kind(dec_kind),
    .fetch_jump(fetch_jump), .abort(abort), .cache_reject(cache_reject),
    .cache_fault(cache_fault), .ctl_busy(ctl_busy), .ras_sp(ras_sp)
);

// File: tb/brp_unit_bench.sv
module brp_unit_bench;
    import brp_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [2:0]  dec_kind = 3'd0;
    logic [31:0] dec_pc = '0, dec_lit = '0;
    logic [2:0]  dec_len = 3'd0;
    logic        ex_cond = 1'b0, cache_reject = 1'b0, cache_fault = 1'b0;
    logic        dec_accept, fetch_jump, abort;
    logic [31:0] dec_next_pc, fetch_pc;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;
    logic [31:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    brp_unit u_brp_unit (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_kind(dec_kind),
        .dec_pc(dec_pc), .dec_lit(dec_lit), .dec_len(dec_len),
        .ex_cond(ex_cond), .cache_reject(cache_reject), .cache_fault(cache_fault),
        .dec_accept(dec_accept), .dec_next_pc(dec_next_pc),
        .fetch_jump(fetch_jump), .fetch_pc(fetch_pc), .abort(abort)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input br_kind_e k, input logic [31:0] pc,
                         input logic [31:0] lit, input logic [2:0] len,
                         input logic cond, input logic rej, input logic flt,
                         input bit xj, input logic [31:0] xpc);
        @(negedge clk);
        dec_valid = v; dec_kind = k; dec_pc = pc; dec_lit = lit; dec_len = len;
        ex_cond = cond; cache_reject = rej; cache_fault = flt;
        if (xj) exp_q.push_back(xpc);
        #2;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            drive(1'b0, BK_PLAIN, 32'h0, 32'h0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic plain(input logic cond, input bit xj, input logic [31:0] xpc);
        drive(1'b1, BK_PLAIN, 32'hA0, 32'h0, 3'd1, cond, 1'b0, 1'b0, xj, xpc);
    endtask

    // monitor: every redirect is matched against the expected queue
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (rst_n && fetch_jump) begin
                if (exp_q.size() == 0)
                    chk(1'b0, "R6 unexpected redirect", fetch_pc, 32'hx);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(fetch_pc == e, "R4 redirect address", fetch_pc, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog R9 actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(fetch_jump == 1'b0 && abort == 1'b0, "R1 outputs in reset",
            {fetch_jump, abort}, 32'h0);
        rst_n = 1'b1;
        // R1: first return reads a cleared entry
        drive(1'b1, BK_RET, 32'h50, 32'h0, 3'd1, 0, 0, 0, 1'b1, 32'h0);
        chk(dec_accept == 1'b1, "R1 return accepted after reset", dec_accept, 1);
        idle(5);

        // R3 unconditional jump, R7 refill
        drive(1'b1, BK_JUMP, 32'h100, 32'h40, 3'd1, 0, 0, 0, 1'b1, 32'h140);
        chk(dec_accept == 1'b1, "R3 jump accepted", dec_accept, 1);
        plain(0, 0, 0);
        chk(dec_accept == 1'b0, "R7 dead cycle after jump", dec_accept, 0);
        plain(0, 0, 0);
        chk(dec_accept == 1'b1, "R7 decode resumes", dec_accept, 1);

        // R3 taken, correctly predicted
        drive(1'b1, BK_CJ_T, 32'h200, 32'h20, 3'd3, 0, 0, 0, 1'b1, 32'h220);
        chk(dec_next_pc == 32'h220, "R3 taken next pc", dec_next_pc, 32'h220);
        idle(2);
        drive(1'b0, BK_PLAIN, 0, 0, 3'd1, 1'b0, 0, 0, 1'b0, 0);
        chk(abort == 1'b0, "R4 correct prediction no abort", abort, 0);

        // R2 not taken, mispredicted
        drive(1'b1, BK_CJ_NT, 32'h300, 32'h80, 3'd3, 0, 0, 0, 1'b0, 0);
        chk(dec_next_pc == 32'h303, "R2 not-taken next pc", dec_next_pc, 32'h303);
        chk(dec_accept == 1'b1, "R2 not-taken accepted", dec_accept, 1);
        plain(0, 0, 0);
        plain(0, 0, 0);
        plain(1'b1, 1'b1, 32'h380);
        chk(abort == 1'b1, "R4 abort on mispredict", abort, 1);
        chk(dec_accept == 1'b0, "R6 decode refused in abort", dec_accept, 0);
        plain(0, 0, 0);
        chk(dec_accept == 1'b0, "R7 refill after recovery", dec_accept, 0);

        // R4 taken, mispredicted
        drive(1'b1, BK_CJ_T, 32'h400, 32'h10, 3'd3, 0, 0, 0, 1'b1, 32'h410);
        idle(2);
        drive(1'b0, BK_PLAIN, 0, 0, 3'd1, 1'b1, 0, 0, 1'b1, 32'h403);
        chk(abort == 1'b1, "R4 taken mispredict abort", abort, 1);
        idle(4);

        // R6 younger branch squashed
        drive(1'b1, BK_CJ_NT, 32'h500, 32'h50, 3'd3, 0, 0, 0, 1'b0, 0);
        drive(1'b1, BK_CJ_NT, 32'h503, 32'h30, 3'd3, 0, 0, 0, 1'b0, 0);
        plain(0, 0, 0);
        drive(1'b0, BK_PLAIN, 0, 0, 3'd1, 1'b1, 0, 0, 1'b1, 32'h550);
        drive(1'b0, BK_PLAIN, 0, 0, 3'd1, 1'b1, 0, 0, 1'b0, 0);
        chk(abort == 1'b0, "R6 squashed branch no abort", abort, 0);
        idle(4);

        // R5 reject without fault freezes
        drive(1'b1, BK_CJ_NT, 32'h900, 32'h4, 3'd3, 0, 0, 0, 1'b0, 0);
        plain(0, 0, 0);
        plain(0, 0, 0);
        drive(1'b1, BK_PLAIN, 32'hA0, 0, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 0);
        chk(abort == 1'b0, "R5 reject without fault", abort, 0);
        chk(dec_accept == 1'b0, "R5 decode refused on reject", dec_accept, 0);
        drive(1'b0, BK_PLAIN, 0, 0, 3'd1, 1'b1, 0, 0, 1'b1, 32'h904);
        chk(abort == 1'b1, "R5 branch resumes after reject", abort, 1);
        idle(5);

        // R5 reject with fault
        drive(1'b0, BK_PLAIN, 0, 0, 3'd1, 1'b0, 1'b1, 1'b1, 1'b0, 0);
        chk(abort == 1'b1, "R5 fault aborts", abort, 1);
        plain(0, 0, 0);
        chk(dec_accept == 1'b1, "R5 decode after fault", dec_accept, 1);
        idle(5);

        // R8/R9 call, blocked return, squashed call, accepted return
        drive(1'b1, BK_CALL, 32'h2000, 32'h10, 3'd5, 0, 0, 0, 1'b1, 32'h2010);
        drive(1'b1, BK_RET, 32'h3000, 0, 3'd1, 0, 0, 0, 1'b0, 0);
        chk(dec_accept == 1'b0, "R7 return refused in refill", dec_accept, 0);
        drive(1'b1, BK_RET, 32'h3000, 0, 3'd1, 0, 0, 0, 1'b0, 0);
        chk(dec_accept == 1'b0, "R9 return refused with call in flight", dec_accept, 0);
        idle(2);
        drive(1'b1, BK_CJ_NT, 32'h600, 32'h10, 3'd3, 0, 0, 0, 1'b0, 0);
        drive(1'b1, BK_CALL, 32'h700, 32'h100, 3'd3, 0, 0, 0, 1'b1, 32'h800);
        idle(1);
        drive(1'b0, BK_PLAIN, 0, 0, 3'd1, 1'b1, 0, 0, 1'b1, 32'h610);
        idle(4);
        drive(1'b1, BK_RET, 32'h3000, 0, 3'd1, 0, 0, 0, 1'b1, 32'h2005);
        chk(dec_accept == 1'b1, "R8 return sees retired call only", dec_accept, 1);
        idle(4);

        // R10 wrap of the return stack
        for (int i = 1; i <= 9; i++) begin
            drive(1'b1, BK_CALL, 32'(i) << 12, 32'h10, 3'd5, 0, 0, 0,
                  1'b1, (32'(i) << 12) + 32'h10);
            idle(1);
        end
        idle(3);
        for (int j = 0; j < 9; j++) begin
            int idx;
            idx = (j < 8) ? (9 - j) : 9;
            drive(1'b1, BK_RET, 32'hF000, 0, 3'd1, 0, 0, 0,
                  1'b1, (32'(idx) << 12) + 32'h5);
            chk(dec_accept == 1'b1, "R10 return after wrap accepted", dec_accept, 1);
            idle(4);
        end
        idle(2);
        chk(exp_q.size() == 0, "R6 missing redirect", 32'(exp_q.size()), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule